// File: doc/BRIEF.md
# Transaction Nesting and Status Controller

This block tracks the transactional state of one processing element under a best-effort hardware transactional memory scheme. Nesting is flattened. Nested begin commands only raise a depth counter inside one outer transaction. Any abort discards that whole outer transaction, whatever the depth at which it happens. The core delivers four decoded one-cycle command pulses: begin, end (commit), cancel with a 15-bit immediate, and depth query. The memory side reports two abort causes while a transaction is live: a coherence conflict from another element, and a capacity spill, meaning a transactional line was evicted.

The block returns a status word for each begin. The word is zero on success. When the transaction is later lost, the block delivers a second, nonzero status word that encodes the cause and a retry hint. This second word is the value that software sees on re-entry just after the outer begin. The block pulses a checkpoint-save strobe when the outer transaction opens and a rollback strobe on every abort. The core acts on these strobes. Register checkpoint storage, pipeline flush and the cache are outside the block.

A three-state machine holds the transactional mode:
- `S_IDLE` means no transaction.
- `S_OUTER` means depth 1.
- `S_NESTED` means depth 2 or more.

The transitions are:
- OPEN goes from `S_IDLE` to `S_OUTER` on a begin.
- DEEPEN goes from `S_OUTER` to `S_NESTED` on a begin.
- SHALLOW goes from `S_NESTED` to `S_OUTER` on an end at depth 2.
- RETIRE goes from `S_OUTER` to `S_IDLE` on an end at depth 1.
- ABORT goes from either active state to `S_IDLE`.

All outputs are registered and appear one clock after the command that causes them. Within one cycle the priority is: memory abort, then cancel, then end, then begin. The depth query is independent of the others and reports the depth held before that cycle's command.

Top module: `txn_ctrl`

## Requirements
- R1: While reset is asserted and after it is released, the block is in `S_IDLE`: `in_txn` is 0, every strobe is 0, and a query returns depth 0.
- R2: A begin in `S_IDLE` gives the following in the next cycle: `status_vld`=1 with `status_word`=0, `ckpt_save`=1, and `in_txn`=1.
- R3: A begin at depth d (1 ≤ d < MAX_DEPTH) raises the depth to d+1. It gives `status_vld`=1 with `status_word`=0 and `ckpt_save`=0.
- R4: An end at depth greater than 1 only lowers the depth by one, with no strobe. An end at depth 1 gives `commit_done`=1 and `in_txn`=0 in the next cycle.
- R5: Any abort, at any depth, gives the following in the next cycle: `rollback_req`=1, `status_vld`=1 with a nonzero `status_word`, `in_txn`=0, and depth 0.
- R6: A cancel in a transaction gives a status word with bit 15 (explicit) set and bits 14:0 equal to the immediate. Bit 18 (retry) is set exactly when immediate bit 14 is 1.
- R7: A memory conflict sets status bit 16 and bit 18 (retry). A capacity spill sets bit 17. Both may appear together. The low 15 bits are 0 for a memory abort.
- R8: A query pulse gives `test_vld`=1 in the next cycle, with `test_depth` equal to the depth before that cycle (0 when idle).
- R9: An end or cancel issued in `S_IDLE` gives `cmd_err`=1 and no other strobe, and the block stays idle.
- R10: Memory abort inputs have no effect while the block is in `S_IDLE`.
- R11: When a memory abort and an end arrive in the same cycle, the abort wins: there is a rollback, and `commit_done` stays 0.
- R12: A begin at depth MAX_DEPTH aborts the transaction with status bit 19 (nesting overflow) set alone. The depth never exceeds MAX_DEPTH.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_begin | input | 1 | Begin transaction pulse |
| cmd_end | input | 1 | Commit pulse |
| cmd_cancel | input | 1 | Explicit cancel pulse |
| cmd_query | input | 1 | Depth query pulse |
| cancel_imm | input | 15 | Immediate carried by cancel |
| mem_conflict | input | 1 | Conflict on a line in the read or write set |
| mem_spill | input | 1 | Transactional line evicted (capacity) |
| status_vld | output | 1 | Status word valid for a begin |
| status_word | output | 20 | Zero on success, else the cause bits and the immediate |
| ckpt_save | output | 1 | Take the architectural checkpoint |
| rollback_req | output | 1 | Restore the checkpoint and discard speculative state |
| commit_done | output | 1 | Outer transaction committed |
| cmd_err | output | 1 | End or cancel issued outside a transaction |
| test_vld | output | 1 | Query result valid |
| test_depth | output | DEPTH_W | Nesting depth returned by the query |
| in_txn | output | 1 | Transactional state active |

## Verification
A wrong depth shows up at the latest on the next query one cycle later. It also shows as a misplaced `commit_done` or a missing SHALLOW step, because an end at the wrong depth leaves the block or stays in it one command early. A wrong cause encoding shows up in the same cycle as `rollback_req`, in `status_word`. The bench therefore walks sequences that pass through every state and transition, with queries placed between them. It also checks collisions between abort and end, and the nesting-overflow boundary at the configured maximum.

// File: rtl/txn_pkg.sv
package txn_pkg;
    localparam int IMM_W    = 15;
    localparam int BIT_EXPL = IMM_W;
    localparam int BIT_CONF = IMM_W + 1;
    localparam int BIT_SIZE = IMM_W + 2;
    localparam int BIT_RTRY = IMM_W + 3;
    localparam int BIT_NEST = IMM_W + 4;
    localparam int STATUS_W = IMM_W + 5;

    typedef enum logic [1:0] {
        S_IDLE   = 2'd0,
        S_OUTER  = 2'd1,
        S_NESTED = 2'd2
    } txn_state_e;

    typedef enum logic [1:0] {
        D_HOLD = 2'd0,
        D_INC  = 2'd1,
        D_DEC  = 2'd2,
        D_CLR  = 2'd3
    } depth_op_e;

    typedef struct packed {
        logic             expl;
        logic             conf;
        logic             size;
        logic             nest;
        logic [IMM_W-1:0] imm;
    } cause_t;
endpackage

// File: rtl/txn_depth.sv
module txn_depth #(
    parameter int MAX_DEPTH = 4,
    localparam int DEPTH_W  = $clog2(MAX_DEPTH + 1)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  txn_pkg::depth_op_e  op,
    output logic [DEPTH_W-1:0]  depth,
    output logic                at_max,
    output logic                at_one,
    output logic                at_two
);
    import txn_pkg::*;

    localparam logic [DEPTH_W-1:0] MAXV = DEPTH_W'(MAX_DEPTH);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            depth <= '0;
        end else begin
            unique case (op)
                D_INC:   if (depth != MAXV) depth <= depth + 1'b1;
                D_DEC:   if (depth != '0)   depth <= depth - 1'b1;
                D_CLR:   depth <= '0;
                default: depth <= depth;
            endcase
        end
    end

    assign at_max = (depth == MAXV);
    assign at_one = (depth == DEPTH_W'(1));
    assign at_two = (depth == DEPTH_W'(2));

    assert_depth_bounded_R12: assert property (@(posedge clk) disable iff (!rst_n)
        depth <= MAXV);
    assert_clr_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
        op == D_CLR |=> depth == '0);
endmodule

// File: rtl/txn_status_enc.sv
module txn_status_enc (
    input  txn_pkg::cause_t                 cause,
    output logic [txn_pkg::STATUS_W-1:0]    word
);
    import txn_pkg::*;

    logic retry;

    always_comb begin
        retry = cause.conf | (cause.expl & cause.imm[IMM_W-1]);
        word  = '0;
        word[IMM_W-1:0] = cause.expl ? cause.imm : '0;
        word[BIT_EXPL]  = cause.expl;
        word[BIT_CONF]  = cause.conf;
        word[BIT_SIZE]  = cause.size;
        word[BIT_RTRY]  = retry;
        word[BIT_NEST]  = cause.nest;
    end

    always_comb begin
        if (cause.nest) begin
            assert_nest_alone_R12: assert (!cause.expl && !cause.conf && !cause.size);
        end
    end
endmodule

// File: rtl/txn_ctrl.sv
module txn_ctrl #(
    parameter int MAX_DEPTH = 4,
    localparam int DEPTH_W  = $clog2(MAX_DEPTH + 1)
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          cmd_begin,
    input  logic                          cmd_end,
    input  logic                          cmd_cancel,
    input  logic                          cmd_query,
    input  logic [txn_pkg::IMM_W-1:0]     cancel_imm,
    input  logic                          mem_conflict,
    input  logic                          mem_spill,
    output logic                          status_vld,
    output logic [txn_pkg::STATUS_W-1:0]  status_word,
    output logic                          ckpt_save,
    output logic                          rollback_req,
    output logic                          commit_done,
    output logic                          cmd_err,
    output logic                          test_vld,
    output logic [DEPTH_W-1:0]            test_depth,
    output logic                          in_txn
);
    import txn_pkg::*;

    txn_state_e            st, st_nx;
    depth_op_e             dop;
    logic [DEPTH_W-1:0]    depth;
    logic                  at_max, at_one, at_two;
    cause_t                cause;
    logic [STATUS_W-1:0]   enc_word;

    logic                  do_abort;
    logic                  svld_nx, ckpt_nx, rb_nx, cdone_nx, err_nx;
    logic [STATUS_W-1:0]   sword_nx;

    txn_depth #(.MAX_DEPTH(MAX_DEPTH)) u_depth (
        .clk    (clk),
        .rst_n  (rst_n),
        .op     (dop),
        .depth  (depth),
        .at_max (at_max),
        .at_one (at_one),
        .at_two (at_two)
    );

    txn_status_enc u_enc (
        .cause (cause),
        .word  (enc_word)
    );

    // Next-state and next-output decision
    always_comb begin
        st_nx    = st;
        dop      = D_HOLD;
        cause    = '0;
        do_abort = 1'b0;
        svld_nx  = 1'b0;
        sword_nx = '0;
        ckpt_nx  = 1'b0;
        cdone_nx = 1'b0;
        err_nx   = 1'b0;

        unique case (st)
            S_IDLE: begin
                if (cmd_cancel || cmd_end) begin
                    err_nx = 1'b1;
                end else if (cmd_begin) begin
                    st_nx   = S_OUTER;          // OPEN
                    dop     = D_INC;
                    ckpt_nx = 1'b1;
                    svld_nx = 1'b1;
                end
            end
            S_OUTER, S_NESTED: begin
                if (mem_conflict || mem_spill) begin
                    cause.conf = mem_conflict;
                    cause.size = mem_spill;
                    do_abort   = 1'b1;
                end else if (cmd_cancel) begin
                    cause.expl = 1'b1;
                    cause.imm  = cancel_imm;
                    do_abort   = 1'b1;
                end else if (cmd_end) begin
                    if (at_one) begin
                        st_nx    = S_IDLE;      // RETIRE
                        dop      = D_CLR;
                        cdone_nx = 1'b1;
                    end else begin
                        dop = D_DEC;
                        if (at_two) st_nx = S_OUTER;   // SHALLOW
                    end
                end else if (cmd_begin) begin
                    if (at_max) begin
                        cause.nest = 1'b1;
                        do_abort   = 1'b1;
                    end else begin
                        st_nx   = S_NESTED;     // DEEPEN (or stay nested)
                        dop     = D_INC;
                        svld_nx = 1'b1;
                    end
                end
            end
            default: st_nx = S_IDLE;
        endcase

        if (do_abort) begin
            st_nx    = S_IDLE;                  // ABORT
            dop      = D_CLR;
            svld_nx  = 1'b1;
            sword_nx = enc_word;
        end
        rb_nx = do_abort;
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= S_IDLE;
        else        st <= st_nx;
    end

    // Registered outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            status_vld   <= 1'b0;
            status_word  <= '0;
            ckpt_save    <= 1'b0;
            rollback_req <= 1'b0;
            commit_done  <= 1'b0;
            cmd_err      <= 1'b0;
            test_vld     <= 1'b0;
            test_depth   <= '0;
        end else begin
            status_vld   <= svld_nx;
            status_word  <= sword_nx;
            ckpt_save    <= ckpt_nx;
            rollback_req <= rb_nx;
            commit_done  <= cdone_nx;
            cmd_err      <= err_nx;
            test_vld     <= cmd_query;
            test_depth   <= cmd_query ? depth : '0;
        end
    end

    assign in_txn = (st != S_IDLE);

    assert_ckpt_from_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ckpt_save |-> $past(st) == S_IDLE && in_txn);
    assert_rollback_leaves_R5: assert property (@(posedge clk) disable iff (!rst_n)
        rollback_req |-> !in_txn && depth == '0 && status_word != '0);
    assert_retire_from_one_R4: assert property (@(posedge clk) disable iff (!rst_n)
        commit_done |-> $past(depth) == DEPTH_W'(1) && !in_txn);
    assert_err_no_change_R9: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_err |-> !in_txn && !status_vld && !rollback_req);
    assert_idle_ignores_mem_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (st == S_IDLE && !cmd_begin) |=> !rollback_req && !in_txn);
    assert_abort_beats_end_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (st != S_IDLE && cmd_end && (mem_conflict || mem_spill)) |=> rollback_req && !commit_done);
    assert_state_depth_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (st == S_OUTER) == (depth == DEPTH_W'(1)));
endmodule

// File: tb/tb_txn_ctrl.sv
module tb_txn_ctrl;
    localparam int MAXD = 4;
    localparam int DW   = $clog2(MAXD + 1);

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_begin = 0, cmd_end = 0, cmd_cancel = 0, cmd_query = 0;
    logic [14:0] cancel_imm = '0;
    logic        mem_conflict = 0, mem_spill = 0;
    logic        status_vld, ckpt_save, rollback_req, commit_done, cmd_err, test_vld, in_txn;
    logic [19:0] status_word;
    logic [DW-1:0] test_depth;

    int total = 0;
    int bad = 0;

    always #5 clk = ~clk;

    txn_ctrl #(.MAX_DEPTH(MAXD)) dut (
        .clk(clk), .rst_n(rst_n),
        .cmd_begin(cmd_begin), .cmd_end(cmd_end), .cmd_cancel(cmd_cancel),
        .cmd_query(cmd_query), .cancel_imm(cancel_imm),
        .mem_conflict(mem_conflict), .mem_spill(mem_spill),
        .status_vld(status_vld), .status_word(status_word), .ckpt_save(ckpt_save),
        .rollback_req(rollback_req), .commit_done(commit_done), .cmd_err(cmd_err),
        .test_vld(test_vld), .test_depth(test_depth), .in_txn(in_txn)
    );

    // in: begin,end,cancel,query,conflict,spill,imm
    // out: svld,sword,ckpt,rb,cdone,err,tvld,tdepth,intxn
    typedef struct packed {
        logic [5:0]  cmd;
        logic [14:0] imm;
        logic        svld;
        logic [19:0] sword;
        logic        ckpt;
        logic        rb;
        logic        cdone;
        logic        err;
        logic        tvld;
        logic [2:0]  tdep;
        logic        intx;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 23;
    localparam vec_t VT [NV] = '{
        '{6'b000100, 15'h0,    1'b0, 20'h0,     1'b0,1'b0,1'b0,1'b0,1'b1,3'd0,1'b0,4'd8},  // R8 idle query
        '{6'b010000, 15'h0,    1'b0, 20'h0,     1'b0,1'b0,1'b0,1'b1,1'b0,3'd0,1'b0,4'd9},  // R9 end idle
        '{6'b001000, 15'h7,    1'b0, 20'h0,     1'b0,1'b0,1'b0,1'b1,1'b0,3'd0,1'b0,4'd9},  // R9 cancel idle
        '{6'b000011, 15'h0,    1'b0, 20'h0,     1'b0,1'b0,1'b0,1'b0,1'b0,3'd0,1'b0,4'd10}, // R10
        '{6'b100000, 15'h0,    1'b1, 20'h0,     1'b1,1'b0,1'b0,1'b0,1'b0,3'd0,1'b1,4'd2},  // R2
        '{6'b000100, 15'h0,    1'b0, 20'h0,     1'b0,1'b0,1'b0,1'b0,1'b1,3'd1,1'b1,4'd8},
        '{6'b100000, 15'h0,    1'b1, 20'h0,     1'b0,1'b0,1'b0,1'b0,1'b0,3'd0,1'b1,4'd3},  // R3
        '{6'b000100, 15'h0,    1'b0, 20'h0,     1'b0,1'b0,1'b0,1'b0,1'b1,3'd2,1'b1,4'd8},
        '{6'b010000, 15'h0,    1'b0, 20'h0,     1'b0,1'b0,1'b0,1'b0,1'b0,3'd0,1'b1,4'd4},  // R4 shallow
        '{6'b000100, 15'h0,    1'b0, 20'h0,     1'b0,1'b0,1'b0,1'b0,1'b1,3'd1,1'b1,4'd4},
        '{6'b010000, 15'h0,    1'b0, 20'h0,     1'b0,1'b0,1'b1,1'b0,1'b0,3'd0,1'b0,4'd4},  // R4 retire
        '{6'b100000, 15'h0,    1'b1, 20'h0,     1'b1,1'b0,1'b0,1'b0,1'b0,3'd0,1'b1,4'd2},
        '{6'b100000, 15'h0,    1'b1, 20'h0,     1'b0,1'b0,1'b0,1'b0,1'b0,3'd0,1'b1,4'd3},
        '{6'b001000, 15'h4005, 1'b1, 20'h4C005, 1'b0,1'b1,1'b0,1'b0,1'b0,3'd0,1'b0,4'd6},  // R6 retry
        '{6'b000100, 15'h0,    1'b0, 20'h0,     1'b0,1'b0,1'b0,1'b0,1'b1,3'd0,1'b0,4'd5},  // R5 depth 0
        '{6'b100000, 15'h0,    1'b1, 20'h0,     1'b1,1'b0,1'b0,1'b0,1'b0,3'd0,1'b1,4'd2},
        '{6'b010010, 15'h0,    1'b1, 20'h50000, 1'b0,1'b1,1'b0,1'b0,1'b0,3'd0,1'b0,4'd11}, // R11
        '{6'b100000, 15'h0,    1'b1, 20'h0,     1'b1,1'b0,1'b0,1'b0,1'b0,3'd0,1'b1,4'd2},
        '{6'b000001, 15'h0,    1'b1, 20'h20000, 1'b0,1'b1,1'b0,1'b0,1'b0,3'd0,1'b0,4'd7},  // R7 spill
        '{6'b100000, 15'h0,    1'b1, 20'h0,     1'b1,1'b0,1'b0,1'b0,1'b0,3'd0,1'b1,4'd2},
        '{6'b001000, 15'h0123, 1'b1, 20'h08123, 1'b0,1'b1,1'b0,1'b0,1'b0,3'd0,1'b0,4'd6},  // R6 no retry
        '{6'b100000, 15'h0,    1'b1, 20'h0,     1'b1,1'b0,1'b0,1'b0,1'b0,3'd0,1'b1,4'd2},
        '{6'b000011, 15'h0,    1'b1, 20'h70000, 1'b0,1'b1,1'b0,1'b0,1'b0,3'd0,1'b0,4'd7}   // R7 both
    };

    task automatic drive(input logic [5:0] c, input logic [14:0] imm);
        {cmd_begin, cmd_end, cmd_cancel, cmd_query, mem_conflict, mem_spill} = c;
        cancel_imm = imm;
    endtask

    task automatic check_all(input string tag, input logic svld, input logic [19:0] sword,
                             input logic ck, input logic rb, input logic cd, input logic er,
                             input logic tv, input logic [2:0] td, input logic it);
        logic [31:0] act, exp;
        total++;
        act = {svld === status_vld, sword === status_word, ck === ckpt_save,
               rb === rollback_req, cd === commit_done, er === cmd_err,
               tv === test_vld, td === 3'(test_depth), it === in_txn};
        exp = 32'h1FF;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: got sv=%b sw=%h ck=%b rb=%b cd=%b er=%b tv=%b td=%0d it=%b exp sv=%b sw=%h ck=%b rb=%b cd=%b er=%b tv=%b td=%0d it=%b",
                     tag, status_vld, status_word, ckpt_save, rollback_req, commit_done,
                     cmd_err, test_vld, test_depth, in_txn,
                     svld, sword, ck, rb, cd, er, tv, td, it);
        end
    endtask

    task automatic step(input logic [5:0] c, input logic [14:0] imm);
        drive(c, imm);
        @(negedge clk);
        drive(6'b0, 15'h0);
    endtask

    initial begin
        #400000;
        bad++; total++;
        $display("FAIL watchdog: got timeout exp completion");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check_all("R1 in reset", 0, 0, 0, 0, 0, 0, 0, 0, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check_all("R1 after reset", 0, 0, 0, 0, 0, 0, 0, 0, 0);

        for (int i = 0; i < NV; i++) begin
            step(VT[i].cmd, VT[i].imm);
            check_all($sformatf("R%0d vec %0d", VT[i].req, i), VT[i].svld, VT[i].sword,
                      VT[i].ckpt, VT[i].rb, VT[i].cdone, VT[i].err,
                      VT[i].tvld, VT[i].tdep, VT[i].intx);
        end

        // R12: fill to maximum depth, then overflow
        for (int k = 0; k < MAXD; k++) step(6'b100000, 15'h0);
        step(6'b000100, 15'h0);
        check_all("R12 at max", 0, 0, 0, 0, 0, 0, 1, 3'(MAXD), 1);
        step(6'b100000, 15'h0);
        check_all("R12 nest overflow", 1, 20'h80000, 0, 1, 0, 0, 0, 0, 0);
        step(6'b000100, 15'h0);
        check_all("R12 depth after", 0, 0, 0, 0, 0, 0, 1, 0, 0);

        // R5: abort from deep nesting with a conflict
        step(6'b100000, 15'h0);
        step(6'b100000, 15'h0);
        step(6'b100000, 15'h0);
        step(6'b000010, 15'h0);
        check_all("R5 deep conflict", 1, 20'h50000, 0, 1, 0, 0, 0, 0, 0);
        step(6'b010000, 15'h0);
        check_all("R5 end after abort", 0, 0, 0, 0, 0, 1, 0, 0, 0);

        // R1: reset in the middle of a transaction
        step(6'b100000, 15'h0);
        step(6'b100000, 15'h0);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check_all("R1 mid-txn reset", 0, 0, 0, 0, 0, 0, 0, 0, 0);
        step(6'b000100, 15'h0);
        check_all("R1 depth after reset", 0, 0, 0, 0, 0, 0, 1, 0, 0);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule